// File: doc/BRIEF.md
# Oversampling Serial Receiver With Per-Character Error Tags

This block recovers asynchronous serial characters from a single input line. It runs from a one-cycle clock enable that pulses sixteen times per bit period. It finds the start bit, confirms the start bit half a bit later, and samples each following bit at its centre. It removes the framing and parity bits and writes the character into a sixteen-entry receive queue. Each queue entry carries its own parity, framing and break flags, so a host that reads the queue later still sees which character went wrong.

The host reads the queue through a valid/ready stream port. `rd_valid` is high while the queue holds at least one entry. The head entry's data and flags appear on the read port, and the host removes the entry by holding `rd_ready` high in a cycle where `rd_valid` is high. The host may hold `rd_ready` low for as long as it likes. While it does, the head entry stays unchanged. Newly received characters collect behind the head until the queue is full, and then further characters are lost and the sticky overrun flag is set. Word length and parity mode are plain configuration inputs and must stay steady while a character is arriving.

Top module: `uart_rx_os`

## Requirements
- R1: After reset, `rd_valid` and `ovr_flag` are 0.
- R2: A low line seen on an oversampling tick starts a start-bit check. Eight ticks later the line is sampled again. If it is high at that point, the start is discarded, no character is produced, and the receiver returns to idle.
- R3: Data bits are sampled sixteen ticks apart, least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The character is right-justified in `rd_data`, and the unused upper bits read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. If `cfg_par_even` is 1, `rd_perr` is set when the data bits plus the parity bit contain an odd number of ones. If `cfg_par_even` is 0, `rd_perr` is set when they contain an even number of ones. When `cfg_par_en` is 0, no parity bit is expected and `rd_perr` is 0.
- R5: When the stop bit is sampled low, the entry carries `rd_ferr`=1. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: When the line is low at every sample of a frame (start, data, parity and stop), exactly one entry is written, with data 0, `rd_brk`=1 and `rd_ferr`=1. No further character is produced until the line has returned high.
- R7: The queue holds up to 16 entries and returns them in arrival order. Each entry keeps its own flags.
- R8: `rd_valid` is 1 whenever the queue is not empty. An entry is removed in a cycle where `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, the read port does not change.
- R9: When a character completes with the queue full and no read in the same cycle, the character is dropped and `ovr_flag` is set. `ovr_flag` stays set until a cycle with `ovr_clr`=1. If a new overrun occurs in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, one cycle, 16 per bit |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_valid | output | 1 | Queue holds an entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked by assertions on every cycle:
- the queue fill level never goes past sixteen and changes by at most one per cycle;
- the read port holds still under back-pressure;
- a break entry always reads zero with the framing flag set;
- the overrun flag rises only out of a full queue, and it clears only on a clear request.

Other behaviour can only be shown by the bench's scenarios:
- bit ordering and right-justification for each word length;
- the parity verdict in both senses;
- rejection of a short low glitch;
- the single entry produced by a long low line, followed by recovery;
- the exact sixteen-entry boundary at which characters start to be dropped.

// File: rtl/rx_pkg.sv
package rx_pkg;
  parameter int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] cfg_len,
  input  logic      par_en,
  input  logic      par_even,
  output logic      ch_valid,
  output rx_entry_t ch
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  tcnt;
  logic [2:0]        bitn;
  logic [CHAR_W-1:0] shreg;
  logic              par_acc;
  logic              all_low;

  logic [2:0]        last_bit;
  logic [CHAR_W-1:0] justified;
  logic              is_break;

  assign last_bit  = 3'd4 + {1'b0, cfg_len};
  assign justified = shreg >> (3'd3 - {1'b0, cfg_len});
  assign is_break  = all_low & ~rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bitn     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      all_low  <= 1'b0;
      ch_valid <= 1'b0;
      ch       <= '0;
    end else begin
      ch_valid <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rx) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (rx) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_DATA;
                bitn    <= '0;
                par_acc <= 1'b0;
                all_low <= 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == LAST) begin
              shreg   <= {rx, shreg[CHAR_W-1:1]};
              par_acc <= par_acc ^ rx;
              all_low <= all_low & ~rx;
              bitn    <= bitn + 1'b1;
              if (bitn == last_bit) state <= par_en ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == LAST) begin
              par_acc <= par_acc ^ rx;
              all_low <= all_low & ~rx;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == LAST) begin
              ch_valid <= 1'b1;
              ch.brk   <= is_break;
              ch.ferr  <= ~rx;
              ch.perr  <= ~is_break & par_en & (par_acc ^ ~par_even);
              ch.data  <= is_break ? '0 : justified;
              state    <= rx ? ST_IDLE : ST_WAIT_HI;
            end
          end
          ST_WAIT_HI: begin
            if (rx) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  rx_entry_t                push_item,
  input  logic                     pop,
  output rx_entry_t                head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   fill
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   rptr;

  assign empty = (fill == '0);
  assign full  = (fill == (AW+1)'(DEPTH));
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_item;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_serial,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_even,
  input  logic                ovr_clr,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [CHAR_W-1:0]   rd_data,
  output logic                rd_perr,
  output logic                rd_ferr,
  output logic                rd_brk,
  output logic                ovr_flag
);
  localparam int FW = $clog2(DEPTH) + 1;

  logic           rx_s;
  logic           ch_valid;
  rx_entry_t      ch;
  rx_entry_t      head;
  logic           empty;
  logic           full;
  logic [FW-1:0]  fill;
  logic           pop;
  logic           push;
  logic           drop;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (rx_s)
  );

  rx_framer #(.OSR(OSR)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (os_tick),
    .rx      (rx_s),
    .cfg_len (cfg_len),
    .par_en  (cfg_par_en),
    .par_even(cfg_par_even),
    .ch_valid(ch_valid),
    .ch      (ch)
  );

  assign pop  = rd_ready & ~empty;
  assign push = ch_valid & (~full | pop);
  assign drop = ch_valid & full & ~pop;

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_item(ch),
    .pop      (pop),
    .head     (head),
    .empty    (empty),
    .full     (full),
    .fill     (fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_flag <= 1'b0;
    else if (drop)    ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end

  assign rd_valid = ~empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_brk   = head.brk;
endmodule

// File: rtl/uart_rx_os_checks.sv
module uart_rx_os_checks #(
  parameter int DEPTH = 16,
  parameter int FW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic          rd_perr,
  input logic          rd_ferr,
  input logic          rd_brk,
  input logic          ovr_flag,
  input logic          ovr_clr,
  input logic [FW-1:0] fill
);
  // R7: queue occupancy stays within its capacity
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R7: occupancy moves by at most one entry per cycle
  p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill == $past(fill) - 1'b1));

  // R8: head entry holds still under back-pressure
  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_perr)
                                 && $stable(rd_ferr) && $stable(rd_brk)));

  // R6: a break entry reads zero with the framing flag set
  p_break_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_brk) |-> (rd_data == 8'h00 && rd_ferr && !rd_perr));

  // R9: overrun only rises out of a full queue
  p_ovr_from_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> ($past(fill) == FW'(DEPTH)));

  // R9: overrun only falls on a clear request
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));
endmodule

bind uart_rx_os uart_rx_os_checks #(.DEPTH(DEPTH), .FW(FW)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_data (rd_data),
  .rd_perr (rd_perr),
  .rd_ferr (rd_ferr),
  .rd_brk  (rd_brk),
  .ovr_flag(ovr_flag),
  .ovr_clr (ovr_clr),
  .fill    (fill)
);

// File: tb/sim_uart_rx_os.sv
`timescale 1ns/1ps
module sim_uart_rx_os;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_serial = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       rd_ready = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, ovr_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  int tdiv = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV-1);
  end

  uart_rx_os u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_serial(rx_serial),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .ovr_clr(ovr_clr), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .ovr_flag(ovr_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: an entry leaves the queue at the next edge
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected entry", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, 32'hFFFF);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check({rd_brk, rd_ferr, rd_perr, rd_data} == e, "R3/R4/R5/R6/R7 entry",
              {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, e});
      end
    end
  end

  task automatic line(input logic b, input int bits);
    rx_serial = b;
    repeat (bits * BIT_CLK) @(posedge clk);
    #2;
  endtask

  // Driver: sends one frame with the current config and records what is expected
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop,
                            input bit expect_entry);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(cfg_len);
    m  = d & 8'((1 << nb) - 1);
    p  = cfg_par_even ? ^m : ~^m;
    if (bad_par) p = ~p;
    if (expect_entry)
      exp_q.push_back({1'b0, ~stop, cfg_par_en & bad_par, m});
    line(1'b0, 1);
    for (int i = 0; i < nb; i++) line(m[i], 1);
    if (cfg_par_en) line(p, 1);
    line(stop, 1);
    if (!stop) line(1'b1, 1);
    line(1'b1, 1);
  endtask

  task automatic drained(input string req);
    repeat (40) @(posedge clk);
    #2;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(rd_valid == 1'b0, req, rd_valid, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    // R1: reset state
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check(ovr_flag == 1'b0, "R1 ovr_flag", ovr_flag, 0);
    rst_n = 1'b1;
    rd_ready = 1'b1;
    line(1'b1, 2);

    // R3: eight data bits, no parity
    send_frame(8'hA5, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1);
    send_frame(8'hFF, 0, 1, 1);
    drained("R3 8-bit");

    // R3/R4: shorter words with each parity sense
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    send_frame(8'h1B, 0, 1, 1);
    cfg_len = 2'd1; cfg_par_even = 1'b0;
    send_frame(8'h2D, 0, 1, 1);
    cfg_len = 2'd2; cfg_par_even = 1'b1;
    send_frame(8'h6E, 0, 1, 1);
    drained("R3 short words");

    // R4: wrong parity bit in both senses
    send_frame(8'h35, 1, 1, 1);
    cfg_par_even = 1'b0;
    send_frame(8'h35, 1, 1, 1);
    drained("R4 parity error");

    // R5: stop bit low, nonzero data
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    send_frame(8'h3C, 0, 0, 1);
    drained("R5 framing");

    // R2: short low glitch produces nothing, then a normal frame arrives
    line(1'b0, 0);
    rx_serial = 1'b0;
    repeat (4 * TICK_DIV) @(posedge clk);
    #2;
    line(1'b1, 2);
    drained("R2 false start");
    send_frame(8'h5A, 0, 1, 1);
    drained("R2 recovery");

    // R6: line held low well beyond a frame yields one entry
    exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    line(1'b0, 14);
    line(1'b1, 2);
    drained("R6 break");
    send_frame(8'h81, 0, 1, 1);
    drained("R6 recovery");

    // R9/R8: fill the queue with the reader stalled
    rd_ready = 1'b0;
    for (int k = 0; k < 16; k++) send_frame(8'(8'h10 + k), 0, 1, 1);
    check(ovr_flag == 1'b0, "R9 no overrun at 16", ovr_flag, 0);
    check(rd_valid == 1'b1, "R8 valid while stalled", rd_valid, 1);
    check(rd_data == 8'h10, "R8 head held", rd_data, 8'h10);
    send_frame(8'hEE, 0, 1, 0);
    check(ovr_flag == 1'b1, "R9 overrun set", ovr_flag, 1);
    repeat (20) @(posedge clk);
    #2;
    check(ovr_flag == 1'b1, "R9 overrun sticky", ovr_flag, 1);
    ovr_clr = 1'b1;
    @(posedge clk);
    #2;
    ovr_clr = 1'b0;
    check(ovr_flag == 1'b0, "R9 overrun cleared", ovr_flag, 0);
    rd_ready = 1'b1;
    drained("R7 order after overrun");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule